// File: doc/BRIEF.md
# Memory Directory Bit Controller

This block sits in the request path of a memory controller and keeps one coherence bit beside every line stored in memory. A set bit means that some other coherence domain may hold a dirty copy of the line. A clear bit means that memory is up to date with respect to all remote domains. The controller reads the bit together with the data. It decides whether the requester must wait for the remote snoop result. It then rewrites the bit according to who asked and what was granted.

The bit lives in the spare check-bit storage of the line. Changing it therefore costs a write of the whole line. Such writes go into a small write queue that drains to memory. Later requests to a line that is still in the queue take their data and bit from the newest queued copy. Requests are handled strictly one at a time. This also guarantees that only one request per line address is ever in flight. For a local read, the memory read and the remote snoop are launched in the same cycle by default. A parameter can instead delay the snoop until memory shows the bit set.

Top module: `memdir_ctrl`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, mem_rd_valid, snp_valid and mem_wr_valid are all 0.
- R2: With the default concurrent snoop option, a local read (req_kind 0) that misses the write queue raises mem_rd_valid and snp_valid in the same cycle, exactly once each.
- R3: A local read that finds the bit clear returns the memory data with rsp_dir 0 before the snoop response arrives. The controller stays busy (req_ready 0) until that snoop response has come back, and no line write results.
- R4: A local read that finds the bit set raises rsp_valid only after the snoop response. If snp_resp_hit is 1, the returned data is snp_resp_data; otherwise it is the memory data. rsp_dir is 1.
- R5: A local read that finds the bit set writes the returned data back to the line with the bit cleared. Queued line writes hold address and data stable while mem_wr_ready is low.
- R6: A remote ownership read (req_kind 1) returns the memory data and the stored bit. If the bit was clear, it writes the same data back with the bit set. If the bit was already set, it writes nothing.
- R7: A remote writeback (req_kind 2) responds with rsp_data equal to req_wdata and rsp_dir 0. It stores that data with the bit cleared, without any memory read.
- R8: A remote shared read (req_kind 3) returns the data and the bit. It issues no snoop and changes neither the data nor the bit.
- R9: A request to a line that has an undrained write in the queue takes its data and bit from the newest queued copy and issues no memory read.
- R10: req_ready drops for the cycles from acceptance to completion of a request. It also stays 0 while the write queue holds WQ_DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_kind | input | 2 | 0 local read, 1 remote ownership read, 2 remote writeback, 3 remote shared read |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Line data for a remote writeback |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DATA_W | Line data returned |
| rsp_dir | output | 1 | Directory bit as read for the line (0 for a writeback) |
| mem_rd_valid | output | 1 | Memory read request pulse |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_resp_valid | input | 1 | Memory read data present |
| mem_rd_resp_data | input | DATA_W | Line data from memory |
| mem_rd_resp_dir | input | 1 | Directory bit stored with the line |
| mem_wr_valid | output | 1 | Line write pending |
| mem_wr_ready | input | 1 | Memory accepts the line write |
| mem_wr_addr | output | ADDR_W | Line write address |
| mem_wr_data | output | DATA_W | Line write data |
| mem_wr_dir | output | 1 | Directory bit written with the line |
| snp_valid | output | 1 | Remote snoop request pulse |
| snp_addr | output | ADDR_W | Snoop address |
| snp_resp_valid | input | 1 | Snoop result present |
| snp_resp_hit | input | 1 | Remote domain supplied modified data |
| snp_resp_data | input | DATA_W | Data from the remote domain |

## Verification
The bench first drives local reads to lines whose bit is clear while the snoop answers slowly. This separates early forwarding from waiting on the snoop. It then sets bits with ownership reads and reads the same lines locally, once with a remote hit and once with a miss. This shows whether remote data wins and whether the bit is cleared in memory afterwards. With the write drain held off, a chain of writeback, local read, ownership read and shared read to one line separates queue forwarding (newest copy, no memory read) from a stale memory read. Filling the queue then shows the intake stall. Repeated ownership reads and shared reads check that an unchanged bit causes no line write.

// File: rtl/memdir_pkg.sv
`timescale 1ns/1ps
package memdir_pkg;
   typedef enum logic [1:0] {
      KIND_LOCAL_RD   = 2'd0,
      KIND_REMOTE_OWN = 2'd1,
      KIND_REMOTE_WB  = 2'd2,
      KIND_REMOTE_SHR = 2'd3
   } req_kind_e;
endpackage

// File: rtl/memdir_policy.sv
`timescale 1ns/1ps
module memdir_policy
   import memdir_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  req_kind_e          kind,
   input  logic [DATA_W-1:0]  mem_data,
   input  logic               mem_dir,
   input  logic               snp_hit,
   input  logic [DATA_W-1:0]  snp_data,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  out_data,
   output logic               new_dir,
   output logic               line_wb
);
   always_comb begin
      out_data = mem_data;
      new_dir  = mem_dir;
      line_wb  = 1'b0;
      unique case (kind)
         KIND_LOCAL_RD: begin
            // remote copy invalidated: bit clears, dirty remote data wins
            if (mem_dir && snp_hit) out_data = snp_data;
            new_dir = 1'b0;
            line_wb = mem_dir;
         end
         KIND_REMOTE_OWN: begin
            new_dir = 1'b1;
            line_wb = !mem_dir;
         end
         KIND_REMOTE_WB: begin
            out_data = wr_data;
            new_dir  = 1'b0;
            line_wb  = 1'b1;
         end
         default: begin
            new_dir = mem_dir;
            line_wb = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/memdir_wq.sv
`timescale 1ns/1ps
module memdir_wq #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_dir,
   output logic              full,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   output logic              lk_dir,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_dir
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("memdir_wq: DEPTH must be a power of two of at least 2");
   end

   logic [ADDR_W-1:0] q_addr [DEPTH];
   logic [DATA_W-1:0] q_data [DEPTH];
   logic              q_dir  [DEPTH];
   logic [PW-1:0]     head, tail;
   logic [CW-1:0]     count;
   logic              pop;

   assign full     = (count == CW'(DEPTH));
   assign wr_valid = (count != '0);
   assign wr_addr  = q_addr[head];
   assign wr_data  = q_data[head];
   assign wr_dir   = q_dir[head];
   assign pop      = wr_valid && wr_ready;

   always_ff @(posedge clk) begin
      if (push) begin
         q_addr[tail] <= push_addr;
         q_data[tail] <= push_data;
         q_dir[tail]  <= push_dir;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // lookup by age: larger age is newer, the newest match wins
   logic [DEPTH-1:0] age_match;
   logic [PW-1:0]    age_slot [DEPTH];
   for (genvar a = 0; a < DEPTH; a++) begin : g_age
      assign age_slot[a]  = head + PW'(a);
      assign age_match[a] = (CW'(a) < count) && (q_addr[age_slot[a]] == lk_addr);
   end

   always_comb begin
      lk_hit  = 1'b0;
      lk_data = '0;
      lk_dir  = 1'b0;
      for (int a = 0; a < DEPTH; a++) begin
         if (age_match[a]) begin
            lk_hit  = 1'b1;
            lk_data = q_data[age_slot[a]];
            lk_dir  = q_dir[age_slot[a]];
         end
      end
   end

   assert_wq_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop);

   assert_wq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready && !push) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_dir)));
endmodule

// File: rtl/memdir_ctrl.sv
`timescale 1ns/1ps
module memdir_ctrl
   import memdir_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int WQ_DEPTH     = 4,
   parameter bit SNOOP_SERIAL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_dir,
   output logic              mem_rd_valid,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_resp_valid,
   input  logic [DATA_W-1:0] mem_rd_resp_data,
   input  logic              mem_rd_resp_dir,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              mem_wr_dir,
   output logic              snp_valid,
   output logic [ADDR_W-1:0] snp_addr,
   input  logic              snp_resp_valid,
   input  logic              snp_resp_hit,
   input  logic [DATA_W-1:0] snp_resp_data
);
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("memdir_ctrl: ADDR_W and DATA_W must be positive");
   end

   req_kind_e         in_kind, cur_kind;
   logic              busy, sent, have_mem, have_snp;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata, m_data, s_data;
   logic              m_dir, s_hit;
   logic              rd_q, snp_q, snp_next;
   logic              accept, mem_ok, gate_snp, wait_snp, rsp_fire, done;
   logic              wq_full, lk_hit, lk_dir;
   logic [DATA_W-1:0] lk_data, pol_data;
   logic              pol_dir, pol_wb;

   assign in_kind   = req_kind_e'(req_kind);
   assign req_ready = !busy && !wq_full;
   assign accept    = req_valid && req_ready;
   assign mem_ok    = have_mem || (cur_kind == KIND_REMOTE_WB);
   assign gate_snp  = (cur_kind == KIND_LOCAL_RD) && m_dir;
   assign rsp_fire  = busy && !sent && mem_ok && (!gate_snp || have_snp);
   assign done      = busy && mem_ok && (!wait_snp || have_snp);

   // snoop launch variant
   if (SNOOP_SERIAL) begin : g_snp_serial
      logic snp_sent;
      assign wait_snp = gate_snp;
      assign snp_next = busy && have_mem && gate_snp && !snp_sent;
      always_ff @(posedge clk) begin
         if (!rst_n)        snp_sent <= 1'b0;
         else if (accept)   snp_sent <= 1'b0;
         else if (snp_next) snp_sent <= 1'b1;
      end
   end else begin : g_snp_parallel
      assign wait_snp = (cur_kind == KIND_LOCAL_RD);
      assign snp_next = accept && (in_kind == KIND_LOCAL_RD);

      assert_concurrent_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_rd_valid && cur_kind == KIND_LOCAL_RD) |-> snp_valid);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         sent      <= 1'b0;
         have_mem  <= 1'b0;
         have_snp  <= 1'b0;
         cur_kind  <= KIND_LOCAL_RD;
         cur_addr  <= '0;
         cur_wdata <= '0;
         m_data    <= '0;
         m_dir     <= 1'b0;
         s_hit     <= 1'b0;
         s_data    <= '0;
         rd_q      <= 1'b0;
         snp_q     <= 1'b0;
      end else begin
         rd_q  <= accept && !lk_hit && (in_kind != KIND_REMOTE_WB);
         snp_q <= snp_next;
         if (accept) begin
            busy      <= 1'b1;
            sent      <= 1'b0;
            cur_kind  <= in_kind;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            have_mem  <= lk_hit;
            m_data    <= lk_data;
            m_dir     <= lk_dir;
            have_snp  <= 1'b0;
            s_hit     <= 1'b0;
         end else begin
            if (busy && mem_rd_resp_valid) begin
               have_mem <= 1'b1;
               m_data   <= mem_rd_resp_data;
               m_dir    <= mem_rd_resp_dir;
            end
            if (busy && snp_resp_valid) begin
               have_snp <= 1'b1;
               s_hit    <= snp_resp_hit;
               s_data   <= snp_resp_data;
            end
            if (rsp_fire) sent <= 1'b1;
            if (done)     busy <= 1'b0;
         end
      end
   end

   memdir_policy #(.DATA_W(DATA_W)) i_policy (
      .kind     (cur_kind),
      .mem_data (m_data),
      .mem_dir  (m_dir),
      .snp_hit  (s_hit),
      .snp_data (s_data),
      .wr_data  (cur_wdata),
      .out_data (pol_data),
      .new_dir  (pol_dir),
      .line_wb  (pol_wb)
   );

   memdir_wq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WQ_DEPTH)) i_wq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (done && pol_wb),
      .push_addr (cur_addr),
      .push_data (pol_data),
      .push_dir  (pol_dir),
      .full      (wq_full),
      .lk_addr   (req_addr),
      .lk_hit    (lk_hit),
      .lk_data   (lk_data),
      .lk_dir    (lk_dir),
      .wr_valid  (mem_wr_valid),
      .wr_ready  (mem_wr_ready),
      .wr_addr   (mem_wr_addr),
      .wr_data   (mem_wr_data),
      .wr_dir    (mem_wr_dir)
   );

   assign rsp_valid    = rsp_fire;
   assign rsp_data     = pol_data;
   assign rsp_dir      = (cur_kind == KIND_REMOTE_WB) ? 1'b0 : m_dir;
   assign mem_rd_valid = rd_q;
   assign mem_rd_addr  = cur_addr;
   assign snp_valid    = snp_q;
   assign snp_addr     = cur_addr;

   assert_one_inflight_R10: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   assert_hold_for_snoop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && cur_kind == KIND_LOCAL_RD && rsp_dir) |-> have_snp);

   assert_shared_no_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_kind == KIND_REMOTE_SHR) |-> !snp_valid);

   assert_wb_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_kind == KIND_REMOTE_WB) |-> !mem_rd_valid);
endmodule

// File: tb/test_memdir_ctrl.sv
`timescale 1ns/1ps
module test_memdir_ctrl;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int DEPTH = 4;
   localparam int MEM_LAT = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_ready;
   logic [1:0]    req_kind = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid, rsp_dir;
   logic [DW-1:0] rsp_data;
   logic          mem_rd_valid;
   logic [AW-1:0] mem_rd_addr;
   logic          mem_rd_resp_valid = 1'b0;
   logic [DW-1:0] mem_rd_resp_data = '0;
   logic          mem_rd_resp_dir = 1'b0;
   logic          mem_wr_valid, mem_wr_dir;
   logic          mem_wr_ready = 1'b1;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;
   logic          snp_valid;
   logic [AW-1:0] snp_addr;
   logic          snp_resp_valid = 1'b0, snp_resp_hit = 1'b0;
   logic [DW-1:0] snp_resp_data = '0;

   memdir_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WQ_DEPTH(DEPTH)) i_memdir_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_dir(rsp_dir),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rd_resp_valid(mem_rd_resp_valid), .mem_rd_resp_data(mem_rd_resp_data),
      .mem_rd_resp_dir(mem_rd_resp_dir),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_dir(mem_wr_dir),
      .snp_valid(snp_valid), .snp_addr(snp_addr),
      .snp_resp_valid(snp_resp_valid), .snp_resp_hit(snp_resp_hit),
      .snp_resp_data(snp_resp_data)
   );

   // memory behind the controller
   logic [DW-1:0] mem_data_a [256];
   logic          mem_dir_a  [256];
   int            n_wr = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) begin
            mem_data_a[i] = 32'hA500_0000 | (i * 32'h0001_0101);
            mem_dir_a[i]  = 1'b0;
         end
      end else if (mem_wr_valid && mem_wr_ready) begin
         mem_data_a[mem_wr_addr] = mem_wr_data;
         mem_dir_a[mem_wr_addr]  = mem_wr_dir;
         n_wr++;
      end
   end

   // read and snoop responders, driven on the falling edge
   bit            wr_hold = 1'b0;
   bit            snp_hit_cfg = 1'b0;
   logic [DW-1:0] snp_data_cfg = '0;
   int            snp_lat_cfg = 8;
   int            rd_timer = 0, snp_timer = 0, cyc = 0;
   int            n_rd = 0, n_snp = 0, n_snp_rsp = 0, rd_cycle = -1, snp_cycle = -2;
   logic [AW-1:0] rd_addr_l = '0;
   always @(negedge clk) begin
      cyc++;
      mem_rd_resp_valid = 1'b0;
      snp_resp_valid    = 1'b0;
      if (rd_timer > 0) begin
         rd_timer--;
         if (rd_timer == 0) begin
            mem_rd_resp_valid = 1'b1;
            mem_rd_resp_data  = mem_data_a[rd_addr_l];
            mem_rd_resp_dir   = mem_dir_a[rd_addr_l];
         end
      end
      if (snp_timer > 0) begin
         snp_timer--;
         if (snp_timer == 0) begin
            snp_resp_valid = 1'b1;
            snp_resp_hit   = snp_hit_cfg;
            snp_resp_data  = snp_data_cfg;
            n_snp_rsp++;
         end
      end
      if (mem_rd_valid) begin
         rd_timer  = MEM_LAT;
         rd_addr_l = mem_rd_addr;
         n_rd++;
         rd_cycle  = cyc;
      end
      if (snp_valid) begin
         snp_timer = snp_lat_cfg;
         n_snp++;
         snp_cycle = cyc;
      end
      mem_wr_ready = !wr_hold;
   end

   // reference view of every line
   logic [DW-1:0] ref_data [256];
   logic          ref_dir  [256];
   int vectors = 0, miscompares = 0, exp_wr = 0;
   int last_rd, last_snp;
   bit last_snp_first, last_busy, last_same;

   task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic run(input string rq, input logic [1:0] kind, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input bit hit, input logic [DW-1:0] sd, input int lat);
      logic [DW-1:0] e_data;
      logic          e_dir;
      int rd0, sn0, sr0;
      e_dir  = ref_dir[a];
      e_data = ref_data[a];
      case (kind)
         2'd0: begin
            if (ref_dir[a]) begin
               if (hit) e_data = sd;
               exp_wr++;
               ref_data[a] = e_data;
               ref_dir[a]  = 1'b0;
            end
         end
         2'd1: if (!ref_dir[a]) begin exp_wr++; ref_dir[a] = 1'b1; end
         2'd2: begin
            e_data = wd; e_dir = 1'b0; exp_wr++;
            ref_data[a] = wd; ref_dir[a] = 1'b0;
         end
         default: ;
      endcase
      snp_hit_cfg = hit; snp_data_cfg = sd; snp_lat_cfg = lat;
      rd0 = n_rd; sn0 = n_snp; sr0 = n_snp_rsp;
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_addr = a; req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      chk(rq, "rsp_data", 64'(rsp_data), 64'(e_data));
      chk(rq, "rsp_dir", 64'(rsp_dir), 64'(e_dir));
      last_snp_first = (n_snp_rsp != sr0);
      last_busy      = !req_ready;
      repeat (16) @(negedge clk);
      last_rd   = n_rd - rd0;
      last_snp  = n_snp - sn0;
      last_same = (rd_cycle == snp_cycle);
   endtask

   initial begin
      #(20 * 150000);
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         ref_data[i] = 32'hA500_0000 | (i * 32'h0001_0101);
         ref_dir[i]  = 1'b0;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "req_ready", 64'(req_ready), 64'd1);
      chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1", "mem_rd_valid", 64'(mem_rd_valid), 64'd0);
      chk("R1", "snp_valid", 64'(snp_valid), 64'd0);
      chk("R1", "mem_wr_valid", 64'(mem_wr_valid), 64'd0);

      // bit clear, slow snoop: early forwarding
      run("R3", 2'd0, 8'h10, '0, 1'b0, '0, 10);
      chk("R3", "snoop before rsp", 64'(last_snp_first), 64'd0);
      chk("R3", "busy at rsp", 64'(last_busy), 64'd1);
      chk("R2", "reads issued", 64'(last_rd), 64'd1);
      chk("R2", "snoops issued", 64'(last_snp), 64'd1);
      chk("R2", "same cycle", 64'(last_same), 64'd1);

      // shared read
      run("R8", 2'd3, 8'h11, '0, 1'b0, '0, 8);
      chk("R8", "snoops issued", 64'(last_snp), 64'd0);

      // ownership read sets the bit, a repeat sees it set
      run("R6", 2'd1, 8'h20, '0, 1'b0, '0, 8);
      run("R6", 2'd1, 8'h20, '0, 1'b0, '0, 8);
      run("R8", 2'd3, 8'h20, '0, 1'b0, '0, 8);

      // bit set: wait for snoop, remote data wins, bit cleared
      run("R4", 2'd0, 8'h20, '0, 1'b1, 32'hCAFE_F00D, 6);
      chk("R4", "snoop before rsp", 64'(last_snp_first), 64'd1);
      run("R6", 2'd1, 8'h21, '0, 1'b0, '0, 8);
      run("R4", 2'd0, 8'h21, '0, 1'b0, 32'h1111_2222, 5);
      chk("R4", "snoop before rsp", 64'(last_snp_first), 64'd1);
      run("R5", 2'd3, 8'h20, '0, 1'b0, '0, 8);
      run("R5", 2'd3, 8'h21, '0, 1'b0, '0, 8);

      // remote writeback
      run("R7", 2'd2, 8'h30, 32'h1234_5678, 1'b0, '0, 8);
      chk("R7", "reads issued", 64'(last_rd), 64'd0);
      run("R7", 2'd3, 8'h30, '0, 1'b0, '0, 8);

      // queue forwarding with drain held
      wr_hold = 1'b1;
      run("R9", 2'd2, 8'h40, 32'h0BAD_CAFE, 1'b0, '0, 8);
      run("R9", 2'd0, 8'h40, '0, 1'b0, '0, 4);
      chk("R9", "reads issued", 64'(last_rd), 64'd0);
      run("R9", 2'd1, 8'h40, '0, 1'b0, '0, 8);
      chk("R9", "reads issued", 64'(last_rd), 64'd0);
      run("R9", 2'd3, 8'h40, '0, 1'b0, '0, 8);
      chk("R9", "reads issued", 64'(last_rd), 64'd0);
      run("R10", 2'd2, 8'h41, 32'h4141_4141, 1'b0, '0, 8);
      run("R10", 2'd2, 8'h42, 32'h4242_4242, 1'b0, '0, 8);
      chk("R10", "ready when full", 64'(req_ready), 64'd0);
      chk("R10", "writes while held", 64'(mem_wr_valid), 64'd1);
      wr_hold = 1'b0;
      repeat (12) @(negedge clk);
      chk("R10", "ready after drain", 64'(req_ready), 64'd1);

      chk("R6", "line writes", 64'(n_wr), 64'(exp_wr));
      chk("R5", "line 20", {31'd0, mem_dir_a[8'h20], mem_data_a[8'h20]}, {31'd0, ref_dir[8'h20], ref_data[8'h20]});
      chk("R5", "line 21", {31'd0, mem_dir_a[8'h21], mem_data_a[8'h21]}, {31'd0, ref_dir[8'h21], ref_data[8'h21]});
      chk("R3", "line 10", {31'd0, mem_dir_a[8'h10], mem_data_a[8'h10]}, {31'd0, ref_dir[8'h10], ref_data[8'h10]});
      chk("R7", "line 30", {31'd0, mem_dir_a[8'h30], mem_data_a[8'h30]}, {31'd0, ref_dir[8'h30], ref_data[8'h30]});
      chk("R9", "line 40", {31'd0, mem_dir_a[8'h40], mem_data_a[8'h40]}, {31'd0, ref_dir[8'h40], ref_data[8'h40]});
      chk("R10", "line 42", {31'd0, mem_dir_a[8'h42], mem_data_a[8'h42]}, {31'd0, ref_dir[8'h42], ref_data[8'h42]});

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule